// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block performs trap entry and trap return for a small 32-bit RISC core. When the pipeline raises an exception, it presents a three-bit type code and the program counter of the faulting instruction. In a single clock the controller sorts the code into one of two classes, normal or debug. It then emits a fetch redirect to the handler slot, emits a write-back of the faulting PC into the link register of that class, and updates the interrupt-enable status bits.

Each class has its own link register and its own saved-enable bit. Debug handlers always sit at an offset from the debug base. Normal handlers sit at an offset from the exception base, unless the debug-control remap bit is set; in that case they move onto the debug base as well. Each handler slot is 32 bytes.

Two return requests reverse the entry. Each one redirects fetch to the link value supplied by the register file and reloads the global enable from the saved bit of its class. The core can also write the status bits directly when no other request is pending.

Top module: `trap_entry_ctrl`

## Requirements
- R1: After reset, the status bits read 0 (bit 0 global enable, bit 1 saved normal enable, bit 2 saved debug enable), and `redir_valid`, `wb_valid` and `bad_code` are all low.
- R2: Codes 2 (instruction bus error), 4 (data bus error), 5 (divide by zero), 6 (interrupt) and 7 (system call) are normal class. One cycle after the request, the block asserts `wb_valid` with `wb_is_dbg`=0 and `wb_data` equal to the faulting PC.
- R3: Codes 1 (breakpoint) and 3 (watchpoint) are debug class. They produce the same write-back with `wb_is_dbg`=1.
- R4: On entry, the saved bit of the taken class becomes its old value OR the old global enable. The global enable becomes 0. The saved bit of the other class is unchanged.
- R5: The redirect target equals the chosen base, with its low 8 bits forced to zero, plus the code times 32. Debug-class codes always use the debug base.
- R6: Normal-class codes use the debug base when `remap_en` is 1 and the exception base when it is 0.
- R7: Code 0 asserts `bad_code` for one cycle. It produces no redirect, no write-back and no status change.
- R8: A normal return redirects to `ea_value` and copies the saved normal enable into the global enable. The saved bits are unchanged.
- R9: A debug return redirects to `ba_value` and copies the saved debug enable into the global enable. The saved bits are unchanged.
- R10: Priority runs exception, then normal return, then debug return, then status write. A lower-priority request arriving in the same cycle is ignored.
- R11: When no other request is taken, `stat_we` loads `stat_wdata` into the status bits on the next edge.
- R12: Every output appears on the clock edge that accepts its request and lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid | input | 1 | Exception request |
| exc_code | input | 3 | Exception type code |
| exc_pc | input | XLEN | PC of the faulting instruction |
| eret_valid | input | 1 | Normal-class return request |
| bret_valid | input | 1 | Debug-class return request |
| ea_value | input | XLEN | Current normal link register value |
| ba_value | input | XLEN | Current debug link register value |
| exc_base | input | XLEN | Exception base register |
| dbg_base | input | XLEN | Debug base register |
| remap_en | input | 1 | Debug-control remap bit |
| stat_we | input | 1 | Direct status write |
| stat_wdata | input | 3 | Status write data |
| redir_valid | output | 1 | Fetch redirect strobe |
| redir_pc | output | XLEN | Redirect target |
| wb_valid | output | 1 | Link register write strobe |
| wb_is_dbg | output | 1 | 1 selects the debug link register |
| wb_data | output | XLEN | Link register write data |
| bad_code | output | 1 | Unrecognised code strobe |
| status | output | 3 | {saved debug enable, saved normal enable, global enable} |

## Verification
The bench builds the block with XLEN=32, 8 alignment bits and a 5-bit slot shift. It therefore reaches addresses near the top of the 32-bit space: a debug base with bit 31 set shows that the full upper field passes through. An exception base with nonzero low bits shows that the alignment mask is applied. Every code from 0 to 7 can be driven. The bench walks the enable bits through entries with the global enable both set and clear, and through conflicting simultaneous requests.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int CODE_W = 3;
  localparam int STAT_W = 3;

  typedef enum logic [CODE_W-1:0] {
    TC_RESET = 3'd0, TC_BKPT = 3'd1, TC_IBUS  = 3'd2, TC_WATCH = 3'd3,
    TC_DBUS  = 3'd4, TC_DIVZ = 3'd5, TC_IRQ   = 3'd6, TC_SCALL = 3'd7
  } trap_code_e;

  typedef enum logic [1:0] { CLS_NONE, CLS_NORMAL, CLS_DEBUG } trap_class_e;

  // Handler address: aligned base plus code scaled to the slot size.
  function automatic logic [63:0] slot_addr(input logic [63:0] base,
                                            input logic [CODE_W-1:0] code,
                                            input int align_bits,
                                            input int slot_shift);
    logic [63:0] mask;
    mask = ~((64'd1 << align_bits) - 64'd1);
    return (base & mask) + (64'(code) << slot_shift);
  endfunction
endpackage

// File: rtl/trap_classify.sv
module trap_classify
  import trap_pkg::*;
(
  input  logic              req,
  input  logic [CODE_W-1:0] code,
  output trap_class_e       cls
);
  always_comb begin
    cls = CLS_NONE;
    if (req) begin
      unique case (trap_code_e'(code))
        TC_BKPT, TC_WATCH:                    cls = CLS_DEBUG;
        TC_IBUS, TC_DBUS, TC_DIVZ, TC_IRQ,
        TC_SCALL:                             cls = CLS_NORMAL;
        default:                              cls = CLS_NONE;
      endcase
    end
  end
endmodule

// File: rtl/trap_vector.sv
module trap_vector
  import trap_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int ALIGN_BITS = 8,
  parameter int SLOT_SHIFT = 5
) (
  input  logic [XLEN-1:0]   exc_base,
  input  logic [XLEN-1:0]   dbg_base,
  input  logic              remap,
  input  logic              is_dbg,
  input  logic [CODE_W-1:0] code,
  output logic              use_dbg_base,
  output logic [XLEN-1:0]   target
);
  logic [63:0] wide;

  assign use_dbg_base = is_dbg | remap;
  assign wide   = slot_addr(64'(use_dbg_base ? dbg_base : exc_base), code,
                            ALIGN_BITS, SLOT_SHIFT);
  assign target = wide[XLEN-1:0];
endmodule

// File: rtl/trap_status.sv
module trap_status
  import trap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enter_norm,
  input  logic              enter_dbg,
  input  logic              ret_norm,
  input  logic              ret_dbg,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_data,
  output logic [STAT_W-1:0] stat
);
  logic ie_q, eie_q, bie_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q <= 1'b0; eie_q <= 1'b0; bie_q <= 1'b0;
    end else if (enter_norm) begin
      eie_q <= eie_q | ie_q;
      ie_q  <= 1'b0;
    end else if (enter_dbg) begin
      bie_q <= bie_q | ie_q;
      ie_q  <= 1'b0;
    end else if (ret_norm) begin
      ie_q <= eie_q;
    end else if (ret_dbg) begin
      ie_q <= bie_q;
    end else if (wr_en) begin
      {bie_q, eie_q, ie_q} <= wr_data;
    end
  end

  assign stat = {bie_q, eie_q, ie_q};

  assert_entry_clears_ie_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_norm || enter_dbg) |=> !stat[0]);
  assert_norm_saves_ie_R4: assert property (@(posedge clk) disable iff (!rst_n)
    enter_norm |=> (stat[1] == ($past(stat[1]) | $past(stat[0]))) && $stable(stat[2]));
  assert_dbg_saves_ie_R4: assert property (@(posedge clk) disable iff (!rst_n)
    enter_dbg |=> (stat[2] == ($past(stat[2]) | $past(stat[0]))) && $stable(stat[1]));
  assert_eret_restores_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ret_norm |=> (stat[0] == $past(stat[1])) && $stable(stat[2:1]));
  assert_bret_restores_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ret_dbg |=> (stat[0] == $past(stat[2])) && $stable(stat[2:1]));
endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int ALIGN_BITS = 8,
  parameter int SLOT_SHIFT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_valid,
  input  logic [2:0]        exc_code,
  input  logic [XLEN-1:0]   exc_pc,
  input  logic              eret_valid,
  input  logic              bret_valid,
  input  logic [XLEN-1:0]   ea_value,
  input  logic [XLEN-1:0]   ba_value,
  input  logic [XLEN-1:0]   exc_base,
  input  logic [XLEN-1:0]   dbg_base,
  input  logic              remap_en,
  input  logic              stat_we,
  input  logic [2:0]        stat_wdata,
  output logic              redir_valid,
  output logic [XLEN-1:0]   redir_pc,
  output logic              wb_valid,
  output logic              wb_is_dbg,
  output logic [XLEN-1:0]   wb_data,
  output logic              bad_code,
  output logic [2:0]        status
);
  localparam logic [XLEN-1:0] ALIGN_MASK = XLEN'((64'd1 << ALIGN_BITS) - 64'd1);

  trap_class_e     cls;
  logic            take_norm, take_dbg, take_bad, take_eret, take_bret, take_wr;
  logic            use_dbg_base;
  logic [XLEN-1:0] vec_target;

  trap_classify u_cls (.req(exc_valid), .code(exc_code), .cls(cls));

  trap_vector #(.XLEN(XLEN), .ALIGN_BITS(ALIGN_BITS), .SLOT_SHIFT(SLOT_SHIFT)) u_vec (
    .exc_base(exc_base), .dbg_base(dbg_base), .remap(remap_en),
    .is_dbg(cls == CLS_DEBUG), .code(exc_code),
    .use_dbg_base(use_dbg_base), .target(vec_target)
  );

  // Request arbitration: exception > normal return > debug return > write.
  assign take_norm = (cls == CLS_NORMAL);
  assign take_dbg  = (cls == CLS_DEBUG);
  assign take_bad  = exc_valid && (cls == CLS_NONE);
  assign take_eret = !exc_valid && eret_valid;
  assign take_bret = !exc_valid && !eret_valid && bret_valid;
  assign take_wr   = !exc_valid && !eret_valid && !bret_valid && stat_we;

  trap_status u_stat (
    .clk(clk), .rst_n(rst_n),
    .enter_norm(take_norm), .enter_dbg(take_dbg),
    .ret_norm(take_eret), .ret_dbg(take_bret),
    .wr_en(take_wr), .wr_data(stat_wdata), .stat(status)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redir_valid <= 1'b0; redir_pc <= '0;
      wb_valid    <= 1'b0; wb_is_dbg <= 1'b0; wb_data <= '0;
      bad_code    <= 1'b0;
    end else begin
      redir_valid <= take_norm | take_dbg | take_eret | take_bret;
      wb_valid    <= take_norm | take_dbg;
      wb_is_dbg   <= take_dbg;
      bad_code    <= take_bad;
      if (take_norm || take_dbg) begin
        redir_pc <= vec_target;
        wb_data  <= exc_pc;
      end else if (take_eret) begin
        redir_pc <= ea_value;
      end else if (take_bret) begin
        redir_pc <= ba_value;
      end
    end
  end

  assert_bad_no_redirect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take_bad |=> bad_code && !redir_valid && !wb_valid && $stable(status));
  assert_wb_with_redirect_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> redir_valid && !bad_code);
  assert_vector_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take_norm || take_dbg) |=> (redir_pc & ALIGN_MASK) == XLEN'(64'($past(exc_code)) << SLOT_SHIFT));
  assert_remap_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_norm && remap_en) |-> use_dbg_base);
  assert_single_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({take_norm, take_dbg, take_bad, take_eret, take_bret, take_wr}));
  assert_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_code && !exc_valid) |=> !bad_code);
endmodule

// File: tb/sim_trap_entry_ctrl.sv
`timescale 1ns/1ps
module sim_trap_entry_ctrl;
  localparam int XLEN = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic exc_valid = 0, eret_valid = 0, bret_valid = 0, remap_en = 0, stat_we = 0;
  logic [2:0] exc_code = 0, stat_wdata = 0;
  logic [XLEN-1:0] exc_pc = 0, ea_value = 0, ba_value = 0, exc_base = 0, dbg_base = 0;
  logic redir_valid, wb_valid, wb_is_dbg, bad_code;
  logic [XLEN-1:0] redir_pc, wb_data;
  logic [2:0] status;

  trap_entry_ctrl #(.XLEN(XLEN), .ALIGN_BITS(8), .SLOT_SHIFT(5)) u0 (.*);

  always #2 clk = ~clk;

  typedef struct {
    string tag;
    logic rv; logic [31:0] rpc; logic wv; logic wd; logic [31:0] wdat;
    logic bad; logic [2:0] st;
  } exp_t;

  exp_t q[$];
  int vectors = 0, miscompares = 0;
  bit done = 0;
  logic m_ie = 0, m_eie = 0, m_bie = 0;

  task automatic drive(string tag, bit ev, logic [2:0] code, logic [31:0] pc,
                       bit er, bit br, bit we, logic [2:0] wd);
    exp_t e;
    bit dbg, norm;
    @(negedge clk);
    exc_valid = ev; exc_code = code; exc_pc = pc;
    eret_valid = er; bret_valid = br; stat_we = we; stat_wdata = wd;
    dbg  = ev && (code == 3'd1 || code == 3'd3);
    norm = ev && !dbg && code != 3'd0;
    e = '{tag: tag, rv: 0, rpc: 'x, wv: 0, wd: 0, wdat: 'x, bad: 0, st: 0};
    if (norm || dbg) begin
      e.rv = 1; e.wv = 1; e.wd = dbg; e.wdat = pc;
      e.rpc = {((dbg || remap_en) ? dbg_base[31:8] : exc_base[31:8]), 8'h00} + 32'(code) * 32;
      if (dbg) m_bie = m_bie | m_ie; else m_eie = m_eie | m_ie;
      m_ie = 0;
    end else if (ev) begin
      e.bad = 1;
    end else if (er) begin
      e.rv = 1; e.rpc = ea_value; m_ie = m_eie;
    end else if (br) begin
      e.rv = 1; e.rpc = ba_value; m_ie = m_bie;
    end else if (we) begin
      {m_bie, m_eie, m_ie} = wd;
    end
    e.st = {m_bie, m_eie, m_ie};
    q.push_back(e);
  endtask

  task automatic idle(); drive("R12 idle", 0, 0, 0, 0, 0, 0, 0); endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      vectors++;
      if (redir_valid !== e.rv || wb_valid !== e.wv || bad_code !== e.bad ||
          status !== e.st || (e.rv && redir_pc !== e.rpc) ||
          (e.wv && (wb_is_dbg !== e.wd || wb_data !== e.wdat))) begin
        miscompares++;
        $display("FAIL %s: got rv=%b pc=%h wv=%b dbg=%b wd=%h bad=%b st=%b exp rv=%b pc=%h wv=%b dbg=%b wd=%h bad=%b st=%b",
          e.tag, redir_valid, redir_pc, wb_valid, wb_is_dbg, wb_data, bad_code, status,
          e.rv, e.rpc, e.wv, e.wd, e.wdat, e.bad, e.st);
      end
    end
  end

  task automatic report();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #40000;
    miscompares++;
    $display("FAIL watchdog: got hang exp completion");
    report();
  end

  initial begin
    exc_base = 32'h0000_4000; dbg_base = 32'h8000_0100;
    ea_value = 32'h0000_1004; ba_value = 32'h0000_2008;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    vectors++;
    if (redir_valid !== 0 || wb_valid !== 0 || bad_code !== 0 || status !== 0) begin
      miscompares++;
      $display("FAIL R1: got rv=%b wv=%b bad=%b st=%b exp 0 0 0 000",
               redir_valid, wb_valid, bad_code, status);
    end
    drive("R11 status write", 0, 0, 0, 0, 0, 1, 3'b001);
    drive("R2 R5 irq entry", 1, 3'd6, 32'h0000_1000, 0, 0, 0, 0);
    drive("R4 divz with ie clear", 1, 3'd5, 32'h0000_1010, 0, 0, 0, 0);
    drive("R8 eret", 0, 0, 0, 1, 0, 0, 0);
    drive("R3 R5 breakpoint", 1, 3'd1, 32'h0000_1020, 0, 0, 0, 0);
    drive("R9 bret", 0, 0, 0, 0, 1, 0, 0);
    drive("R3 watchpoint", 1, 3'd3, 32'h0000_1030, 0, 0, 0, 0);
    idle();
    @(negedge clk); remap_en = 1;
    drive("R6 remap syscall", 1, 3'd7, 32'h0000_1040, 0, 0, 0, 0);
    @(negedge clk); remap_en = 0; exc_base = 32'h0000_40FF;
    drive("R5 base masking dbus", 1, 3'd4, 32'h0000_1050, 0, 0, 0, 0);
    drive("R2 ibus", 1, 3'd2, 32'h0000_1060, 0, 0, 0, 0);
    drive("R11 status write all", 0, 0, 0, 0, 0, 1, 3'b101);
    drive("R7 bad code", 1, 3'd0, 32'h0000_1070, 1, 0, 1, 3'b000);
    idle();
    drive("R10 exc over eret", 1, 3'd6, 32'h0000_1080, 1, 1, 1, 3'b111);
    drive("R10 eret over bret", 0, 0, 0, 1, 1, 1, 3'b000);
    drive("R10 bret over write", 0, 0, 0, 0, 1, 1, 3'b000);
    idle();
    for (int k = 0; k < 8; k++) begin
      drive("R11 set ie", 0, 0, 0, 0, 0, 1, 3'(k));
      drive("R2 R3 R7 code sweep", 1, 3'(k), 32'h0000_2000 + 32'(k) * 4, 0, 0, 0, 0);
    end
    idle(); idle();
    @(negedge clk);
    report();
  end
endmodule